// File: doc/BRIEF.md
# Memory Address Multiplexer and Read Capture

This block sits between a programmable memory-access sequencer and the external memory bus. Each cycle the sequencer hands it a control word that says whether the access is valid, where the address comes from, whether the address is to be multiplexed, whether the access is a read, and how read data is to be timed. The block then drives the external address pins from one of three sources: the internal master's address as it is, the master's address rearranged by a configured 3-bit mux mode, or the value held in a memory address register that software loads elsewhere.

Address bits are numbered in most-significant-first order: A0 is bit 31 of the 32-bit vector and A31 is bit 0. Multiplexing moves a window of master address bits onto the low sixteen pins, A16 to A31. The window moves one bit per mode step. Bus-type and mode settings limit when the register may be driven. A page-interleave setting in the SDRAM controller that shares the bus turns multiplexing off.

On reads, the external data bus is captured either on the rising clock edge, or half a cycle early on the falling edge when the sequencer asks for it. Either way the value reaches the internal master on the next rising edge. All outputs are registered. An address result appears on the rising edge that samples its control word.

Top module: `mem_addr_mux_sample`

## Requirements
- R1: With `ctl_valid`=1, `ctl_src_reg`=0 and `ctl_mux_en`=0, `ext_addr` equals `mst_addr` and `ext_addr_oe` is 1 after the next rising edge.
- R2: With the master source, `ctl_mux_en`=1, `cfg_page_ilv`=0 and `cfg_mux_mode` m in 0..5, pins A0–A15 (vector bits 31:16) carry master A0–A15 unchanged. Pin Ap for p in 16..31 carries master bit A(p−8−m). So in mode 0 pins A16–A31 carry A8–A23, and pin A31 carries A23 down to A18 for modes 0 through 5.
- R3: In multiplexed modes only master bits A5 and higher-numbered bits reach the low pins. Any pin whose source would be A4 or lower is driven 0: pin A16 in mode 4, and pins A16 and A17 in mode 5.
- R4: Mux modes 6 and 7 are reserved. A multiplexed master access in those modes drives `mst_addr` unchanged and raises `mode_err` for that one result cycle only.
- R5: With `cfg_page_ilv`=1, multiplexing is off. A master access drives `mst_addr` unchanged for every mode, and `mode_err` stays 0.
- R6: With `ctl_src_reg`=1 on the primary bus (`cfg_local_bus`=0, `cfg_compat`=0), `ext_addr` equals all 32 bits of `addr_reg` and `ext_addr_oe` is 1.
- R7: With `ctl_src_reg`=1 and `cfg_local_bus`=1, `ext_addr` carries only `addr_reg` bits 17:0, with bits 31:18 zero and `ext_addr_oe` 1. `cfg_compat` has no effect on the local bus.
- R8: With `ctl_src_reg`=1, `cfg_local_bus`=0 and `cfg_compat`=1, the register is not driven: `ext_addr_oe` is 0 and `ext_addr` is 0.
- R9: A cycle with `ctl_valid`=0 gives `ext_addr_oe`=0, `mode_err`=0 and `rd_valid`=0, and `ext_addr` holds its previous value.
- R10: For a valid read with `ctl_ack_tim`=1, `cfg_strobe4_off`=1 and `ctl_half_early`=1, `ext_data` is captured on the falling edge inside the cycle. It appears on `rd_data`, with `rd_valid`=1, exactly one rising edge later.
- R11: For a valid read under any other combination of those three bits, `ext_data` is captured on the rising edge that ends the cycle. A non-read valid access leaves `rd_valid` at 0.
- R12: While `rst` is high, all outputs go to 0 on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Control word valid this cycle |
| ctl_src_reg | input | 1 | 1 selects the address register, 0 the master address |
| ctl_mux_en | input | 1 | Multiplex the master address |
| ctl_read | input | 1 | Access is a read |
| ctl_ack_tim | input | 1 | Transfer-acknowledge timing bit of the control word |
| ctl_half_early | input | 1 | Request falling-edge data capture |
| cfg_mux_mode | input | 3 | Multiplex mode, 0..5 valid, 6..7 reserved |
| cfg_local_bus | input | 1 | Block serves the secondary (local) bus |
| cfg_compat | input | 1 | Compatible mode on the primary bus |
| cfg_page_ilv | input | 1 | Page-based interleaving set in the SDRAM controller on this bus |
| cfg_strobe4_off | input | 1 | General-purpose line 4 disabled, so the timing bit acts as capture control |
| mst_addr | input | 32 | Internal master address |
| addr_reg | input | 32 | Memory address register contents |
| ext_data | input | 32 | External data bus |
| ext_addr | output | 32 | External address pins |
| ext_addr_oe | output | 1 | Address pins driven |
| mode_err | output | 1 | Reserved mux mode used |
| rd_data | output | 32 | Read data to the internal master |
| rd_valid | output | 1 | Read data valid |

## Verification
Every address-side result (`ext_addr`, `ext_addr_oe`, `mode_err`) is due on the first rising edge after the control word is driven. The bench drives just after one rising edge and samples 1 ns after the next. The read path is due on that same edge, so the bench changes `ext_data` between the falling edge and the rising edge. This lets it tell a falling-edge capture from a rising-edge one by the value returned. Each vector is followed by an idle cycle, and some of those idle cycles are checked, to confirm that the error flag lasts one cycle and that the address holds.

// File: rtl/mem_addr_mux_pkg.sv
`timescale 1ns/1ps
package mem_addr_mux_pkg;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int MODE_W      = 3;
  localparam int NUM_MODES   = 6;   // modes 0..5 defined, rest reserved
  localparam int LOW_PINS    = 16;  // pins rewritten by multiplexing
  localparam int BASE_SHIFT  = 8;   // mode 0 window offset
  localparam int LOWEST_MSB  = 5;   // highest-order master bit allowed on low pins (MSB-first index)
  localparam int LOCAL_BITS  = 18;  // register bits driven on the local bus
endpackage

// File: rtl/addr_shift_unit.sv
`timescale 1ns/1ps
module addr_shift_unit
  import mem_addr_mux_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int MW    = MODE_W,
  parameter int NM    = NUM_MODES,
  parameter int LP    = LOW_PINS,
  parameter int BS    = BASE_SHIFT,
  parameter int LMSB  = LOWEST_MSB
) (
  input  logic [AW-1:0] addr_in,
  input  logic [MW-1:0] mode,
  output logic [AW-1:0] addr_out,
  output logic          mode_ok
);
  localparam int MODES_ALL = 1 << MW;

  // one precomputed low-pin pattern per mode; reserved slots are zero
  logic [MODES_ALL-1:0][LP-1:0] pattern;

  genvar m, j;
  generate
    for (m = 0; m < MODES_ALL; m++) begin : g_mode
      for (j = 0; j < LP; j++) begin : g_pin
        // vector bit j takes master vector bit BS+m+j when its MSB-first index is high enough
        if ((m < NM) && ((AW - 1 - (BS + m + j)) >= LMSB)) begin : g_drv
          assign pattern[m][j] = addr_in[BS + m + j];
        end else begin : g_zero
          assign pattern[m][j] = 1'b0;
        end
      end
    end
  endgenerate

  assign mode_ok  = (mode < MW'(NM));
  assign addr_out = {addr_in[AW-1:LP], pattern[mode]};
endmodule

// File: rtl/addr_path.sv
`timescale 1ns/1ps
module addr_path
  import mem_addr_mux_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int MW = MODE_W,
  parameter int NM = NUM_MODES,
  parameter int LB = LOCAL_BITS,
  parameter int LP = LOW_PINS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          src_reg,
  input  logic          mux_en,
  input  logic [MW-1:0] mode,
  input  logic          local_bus,
  input  logic          compat,
  input  logic          page_ilv,
  input  logic [AW-1:0] mst,
  input  logic [AW-1:0] muxed,
  input  logic          mode_ok,
  input  logic [AW-1:0] reg_val,
  output logic [AW-1:0] addr_q,
  output logic          oe_q,
  output logic          err_q
);
  logic mux_on;
  assign mux_on = mux_en && !page_ilv;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      oe_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      oe_q  <= 1'b0;
      err_q <= 1'b0;
      if (valid) begin
        if (src_reg) begin
          if (local_bus) begin
            addr_q <= AW'(reg_val[LB-1:0]);
            oe_q   <= 1'b1;
          end else if (compat) begin
            addr_q <= '0;
          end else begin
            addr_q <= reg_val;
            oe_q   <= 1'b1;
          end
        end else begin
          oe_q   <= 1'b1;
          addr_q <= (mux_on && mode_ok) ? muxed : mst;
          err_q  <= mux_on && !mode_ok;
        end
      end
    end
  end

  a_r4_reserved_err: assert property (@(posedge clk) disable iff (rst)
    (valid && !src_reg && mux_on && (mode >= MW'(NM))) |=> (err_q && addr_q == $past(mst)));
  a_r5_ilv_raw: assert property (@(posedge clk) disable iff (rst)
    (valid && !src_reg && page_ilv) |=> (addr_q == $past(mst) && !err_q));
  a_r7_local_clip: assert property (@(posedge clk) disable iff (rst)
    (valid && src_reg && local_bus) |=> (addr_q[AW-1:LB] == '0 && oe_q));
  a_r8_compat_quiet: assert property (@(posedge clk) disable iff (rst)
    (valid && src_reg && !local_bus && compat) |=> !oe_q);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (!oe_q && !err_q && $stable(addr_q)));
  a_r3_top_pins_zero: assert property (@(posedge clk) disable iff (rst)
    (valid && !src_reg && mux_on && mode == MW'(NM - 1)) |=> (addr_q[LP-1 -: 2] == 2'b00));
endmodule

// File: rtl/rd_capture.sv
`timescale 1ns/1ps
module rd_capture
  import mem_addr_mux_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          early,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] fall_q;

  // half-cycle-early capture point
  always_ff @(negedge clk) begin
    if (rst)         fall_q <= '0;
    else if (cap_en) fall_q <= data_in;
  end

  // hand-off to the internal master on the rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= early ? fall_q : data_in;
    end
  end

  a_r10_read_valid: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> rd_valid);
  a_r11_no_read_no_valid: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> !rd_valid);
endmodule

// File: rtl/mem_addr_mux_sample.sv
`timescale 1ns/1ps
module mem_addr_mux_sample
  import mem_addr_mux_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_valid,
  input  logic          ctl_src_reg,
  input  logic          ctl_mux_en,
  input  logic          ctl_read,
  input  logic          ctl_ack_tim,
  input  logic          ctl_half_early,
  input  logic [MW-1:0] cfg_mux_mode,
  input  logic          cfg_local_bus,
  input  logic          cfg_compat,
  input  logic          cfg_page_ilv,
  input  logic          cfg_strobe4_off,
  input  logic [AW-1:0] mst_addr,
  input  logic [AW-1:0] addr_reg,
  input  logic [DW-1:0] ext_data,
  output logic [AW-1:0] ext_addr,
  output logic          ext_addr_oe,
  output logic          mode_err,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [AW-1:0] muxed;
  logic          mode_ok;
  logic          cap_en;
  logic          early;

  addr_shift_unit #(.AW(AW), .MW(MW)) u_shift (
    .addr_in (mst_addr),
    .mode    (cfg_mux_mode),
    .addr_out(muxed),
    .mode_ok (mode_ok)
  );

  addr_path #(.AW(AW), .MW(MW)) u_path (
    .clk      (clk),
    .rst      (rst),
    .valid    (ctl_valid),
    .src_reg  (ctl_src_reg),
    .mux_en   (ctl_mux_en),
    .mode     (cfg_mux_mode),
    .local_bus(cfg_local_bus),
    .compat   (cfg_compat),
    .page_ilv (cfg_page_ilv),
    .mst      (mst_addr),
    .muxed    (muxed),
    .mode_ok  (mode_ok),
    .reg_val  (addr_reg),
    .addr_q   (ext_addr),
    .oe_q     (ext_addr_oe),
    .err_q    (mode_err)
  );

  assign cap_en = ctl_valid && ctl_read;
  assign early  = ctl_ack_tim && cfg_strobe4_off && ctl_half_early;

  rd_capture #(.DW(DW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .early   (early),
    .data_in (ext_data),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  a_r12_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!ext_addr_oe && !mode_err && !rd_valid && ext_addr == '0));
endmodule

// File: tb/mem_addr_mux_sample_test.sv
`timescale 1ns/1ps
module mem_addr_mux_sample_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_valid = 0, ctl_src_reg = 0, ctl_mux_en = 0, ctl_read = 0;
  logic        ctl_ack_tim = 0, ctl_half_early = 0;
  logic [2:0]  cfg_mux_mode = 0;
  logic        cfg_local_bus = 0, cfg_compat = 0, cfg_page_ilv = 0, cfg_strobe4_off = 0;
  logic [31:0] mst_addr = 0, addr_reg = 0, ext_data = 0;
  logic [31:0] ext_addr, rd_data;
  logic        ext_addr_oe, mode_err, rd_valid;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  mem_addr_mux_sample uut (
    .clk(clk), .rst(rst), .ctl_valid(ctl_valid), .ctl_src_reg(ctl_src_reg),
    .ctl_mux_en(ctl_mux_en), .ctl_read(ctl_read), .ctl_ack_tim(ctl_ack_tim),
    .ctl_half_early(ctl_half_early), .cfg_mux_mode(cfg_mux_mode),
    .cfg_local_bus(cfg_local_bus), .cfg_compat(cfg_compat), .cfg_page_ilv(cfg_page_ilv),
    .cfg_strobe4_off(cfg_strobe4_off), .mst_addr(mst_addr), .addr_reg(addr_reg),
    .ext_data(ext_data), .ext_addr(ext_addr), .ext_addr_oe(ext_addr_oe),
    .mode_err(mode_err), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // expected address written in pin numbering: pin p (0 = MSB) is vector bit 31-p
  function automatic logic [33:0] model_addr(input logic src, input logic mux, input int mode,
      input logic ilv, input logic lcl, input logic cmp, input logic [31:0] a, input logic [31:0] r);
    logic [31:0] o;
    logic oe, err;
    oe = 1; err = 0; o = a;
    if (src) begin
      if (lcl) o = r & 32'h0003_FFFF;
      else if (cmp) begin o = 0; oe = 0; end
      else o = r;
    end else if (mux && !ilv) begin
      if (mode <= 5) begin
        for (int p = 16; p < 32; p++) begin
          int s;
          s = p - 8 - mode;
          o[31-p] = (s >= 5) ? a[31-s] : 1'b0;
        end
      end else err = 1;
    end
    return {oe, err, o};
  endfunction

  function automatic string tag_of(input logic src, input logic mux, input int mode,
      input logic ilv, input logic lcl, input logic cmp);
    if (src) return lcl ? "R7" : (cmp ? "R8" : "R6");
    if (!mux) return "R1";
    if (ilv) return "R5";
    if (mode >= 6) return "R4";
    if (mode >= 4) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access; data_a is on the bus until after the falling edge, then data_b
  task automatic apply(input logic src, input logic mux, input int mode, input logic ilv,
      input logic lcl, input logic cmp, input logic rd, input logic ack, input logic s4,
      input logic he, input logic [31:0] a, input logic [31:0] r,
      input logic [31:0] data_a, input logic [31:0] data_b);
    logic [33:0] e;
    logic early;
    @(posedge clk); #1;
    ctl_valid = 1; ctl_src_reg = src; ctl_mux_en = mux; cfg_mux_mode = 3'(mode);
    cfg_page_ilv = ilv; cfg_local_bus = lcl; cfg_compat = cmp; ctl_read = rd;
    ctl_ack_tim = ack; cfg_strobe4_off = s4; ctl_half_early = he;
    mst_addr = a; addr_reg = r; ext_data = data_a;
    #6 ext_data = data_b;
    @(posedge clk); #1;
    e = model_addr(src, mux, mode, ilv, lcl, cmp, a, r);
    check(tag_of(src, mux, mode, ilv, lcl, cmp), {30'd0, ext_addr_oe, mode_err, ext_addr},
          {30'd0, e});
    early = ack && s4 && he;
    if (rd) check(early ? "R10" : "R11", {31'd0, rd_valid, rd_data},
                  {31'd0, 1'b1, early ? data_a : data_b});
    else    check("R11", {63'd0, rd_valid}, 64'd0);
    ctl_valid = 0;
  endtask

  // the cycle after an access is idle: nothing driven, address held, flag gone
  task automatic idle_check(input logic [31:0] held);
    @(posedge clk); #1;
    check("R9", {30'd0, ext_addr_oe, mode_err, ext_addr}, {32'd0, held});
    check("R9", {63'd0, rd_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hDEAD_BEEF; pats[1] = 32'h1234_5678;
    pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h0400_0000; // only A5 set
    repeat (3) @(posedge clk);
    #1;
    check("R12", {ext_addr_oe, mode_err, rd_valid, ext_addr, rd_data[28:0]}, 64'd0);
    rst = 0;

    // address sweep: every source, mode and configuration combination
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 32; c++)
        for (int m = 0; m < 8; m++) begin
          logic [33:0] e;
          apply(c[0], c[1], m, c[2], c[3], c[4], 1'b0, 1'b0, 1'b0, 1'b0,
                pats[k], ~pats[(k + 1) % 4], 32'h0, 32'h0);
          if (m[0] && k == 1) begin
            e = model_addr(c[0], c[1], m, c[2], c[3], c[4], pats[k], ~pats[(k + 1) % 4]);
            idle_check(e[31:0]);
          end
        end

    // walking one across the master address in every defined mode
    for (int m = 0; m < 6; m++)
      for (int b = 0; b < 32; b++)
        apply(1'b0, 1'b1, m, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
              32'd1 << b, 32'h0, 32'h0, 32'h0);

    // reserved mode flag lasts one cycle (R4), then idle (R9)
    apply(1'b0, 1'b1, 7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
          32'hCAFE_0001, 32'h0, 32'h0, 32'h0);
    idle_check(32'hCAFE_0001);

    // read timing: every combination of the three capture controls
    for (int c = 0; c < 8; c++)
      for (int d = 0; d < 2; d++)
        apply(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, c[0], c[1], c[2],
              32'h0000_1000, 32'h0, d ? 32'hA5A5_0F0F : 32'h1111_2222,
              d ? 32'h5A5A_F0F0 : 32'h3333_4444);

    // back-to-back early reads, then idle
    apply(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
          32'h2, 32'h0, 32'h0BAD_F00D, 32'hFEED_FACE);
    idle_check(32'h2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule